// File: doc/BRIEF.md
# Device Interrupt Routing Controller

This block gathers up to 64 device interrupt request lines into one shared pending register and routes them to as many as four processors. Each processor slot has its own enable mask. The block keeps a per-slot enabled-request vector, which is the mask ANDed with the pending register, and it drives one level-sensitive interrupt line per processor. That line stays high while any enabled request for the slot is pending.

Devices post and withdraw requests through per-line set and clear strobe vectors. Software uses a simple 64-bit register port. It can program the masks and read back the masks, the enabled-request vectors and the pending register. Each register occupies its own 64-byte window.

An access that the block does not support returns zero and pulses an error flag, and it changes no state. Unsupported accesses are writes to read-only registers, unmapped offsets and unsupported sizes.

Top module: `irq_route_top`

## Requirements
- R1: For every slot, the enabled-request vector equals that slot's mask ANDed with the pending register. Both values are readable through the register port.
- R2: A 64-bit write to a slot's mask replaces that mask only and updates that slot's enabled-request vector at the same clock edge. Enabling a pending line raises the slot's interrupt. Masking the last enabled pending line withdraws it.
- R3: Each cpuIrq bit is the OR of that slot's enabled-request vector, registered once. Consider a strobe or mask write that is sampled at edge k. The vector changes at edge k and cpuIrq changes at edge k+1.
- R4: A set strobe on line n sets pending bit n. It raises the interrupt of every slot whose mask has bit n set, and only of those slots.
- R5: A clear strobe on line n clears pending bit n when that bit is set, and it withdraws the interrupt from slots that no longer have an enabled pending line. A clear for a line that is not pending changes nothing.
- R6: When set and clear strobes for the same line arrive in the same cycle, the line ends up pending.
- R7: The register number is the byte offset shifted right by 6, and the low 6 offset bits must be zero. The numbering is as follows:
  - Numbers 0 to 3 are the slot masks (offsets 0x000, 0x040, 0x080, 0x0C0).
  - Numbers 4 to 7 are the enabled-request vectors of slots 0 to 3 (offsets 0x100 to 0x1C0).
  - Number 8 is the pending register (offset 0x200).
  - Every other offset is unmapped.
- R8: The regSize encoding is 3 for 64-bit, 2 for 32-bit, 1 for 16-bit and 0 for 8-bit. Only 64-bit accesses are valid. The one exception is a 32-bit read of the pending register, which returns its low 32 bits with the upper bits zero.
- R9: An unsupported access leaves all state unchanged, returns regRdata 0 and pulses regErr for one cycle. Unsupported accesses are writes to the vector or pending registers, accesses of any other size, and accesses to unmapped or misaligned offsets.
- R10: regRdata and regErr are registered and valid in the cycle after the access is sampled. Both are 0 when no access is made and after reset, and all registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 12 | Byte offset of the access |
| regSize | input | 2 | Access size code (3 = 64-bit, 2 = 32-bit, 1 = 16-bit, 0 = 8-bit) |
| regWdata | input | 64 | Write data |
| regRdata | output | 64 | Read data, registered |
| regErr | output | 1 | One-cycle pulse for an unsupported access |
| devSet | input | 64 | Per-line request set strobes |
| devClr | input | 64 | Per-line request clear strobes |
| cpuIrq | output | 4 | Per-processor device interrupt |

## Verification
The embedded assertions check several behaviours on every cycle:
- the enabled-request vectors always equal mask AND pending;
- a set strobe on an enabled line always yields a non-zero vector, and a set always beats a simultaneous clear;
- the pending register only moves on a strobe;
- the interrupt lags its vector by one edge;
- an error response carries zero data, and the decoder never combines an error with a write or a read.

Only the bench scenarios can show the rest:
- the register map and the size rules;
- that each single line reaches exactly the right slots across a sweep of all 64 lines with distinct masks;
- that a clear of an idle line and unsupported writes leave readable state intact;
- that mask writes raise and withdraw the interrupt.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int REG_W      = 64;
  localparam int SLOT_MAX   = 4;
  localparam int SLOT_IDX_W = $clog2(SLOT_MAX);
  localparam int WIN_SHIFT  = 6;
  localparam int VEC_BASE   = SLOT_MAX;
  localparam int RAW_NUM    = 2 * SLOT_MAX;

  localparam logic [1:0] SZ_64 = 2'd3;
  localparam logic [1:0] SZ_32 = 2'd2;

  typedef enum logic [1:0] {
    RD_MASK   = 2'd0,
    RD_VEC    = 2'd1,
    RD_RAW    = 2'd2,
    RD_RAW_LO = 2'd3
  } rdKind_e;

  typedef struct packed {
    logic                  maskWe;
    logic [SLOT_IDX_W-1:0] slot;
    logic                  rdEn;
    rdKind_e               rdKind;
    logic                  err;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_CPU = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        regSize,
  output ctrlStrobe_t       ctrl
);

  localparam int IDX_W = ADDR_W - WIN_SHIFT;

  logic [IDX_W-1:0] regNum;
  logic             aligned;
  logic             isMask;
  logic             isVec;
  logic             isRaw;
  logic [IDX_W-1:0] vecOff;

  assign regNum  = regAddr[ADDR_W-1:WIN_SHIFT];
  assign aligned = (regAddr[WIN_SHIFT-1:0] == '0);
  assign vecOff  = regNum - IDX_W'(VEC_BASE);

  always_comb begin
    isMask = aligned && (regNum < IDX_W'(NUM_CPU));
    isVec  = aligned && (regNum >= IDX_W'(VEC_BASE)) &&
             (regNum < IDX_W'(VEC_BASE + NUM_CPU));
    isRaw  = aligned && (regNum == IDX_W'(RAW_NUM));
  end

  always_comb begin
    ctrl        = '0;
    ctrl.rdKind = RD_MASK;
    if (isVec) ctrl.slot = vecOff[SLOT_IDX_W-1:0];
    else       ctrl.slot = regNum[SLOT_IDX_W-1:0];
    if (regValid) begin
      if (regWrite) begin
        if (isMask && regSize == SZ_64) ctrl.maskWe = 1'b1;
        else                             ctrl.err    = 1'b1;
      end else begin
        if (regSize == SZ_64 && (isMask || isVec || isRaw)) begin
          ctrl.rdEn = 1'b1;
          if (isMask)     ctrl.rdKind = RD_MASK;
          else if (isVec) ctrl.rdKind = RD_VEC;
          else            ctrl.rdKind = RD_RAW;
        end else if (regSize == SZ_32 && isRaw) begin
          ctrl.rdEn   = 1'b1;
          ctrl.rdKind = RD_RAW_LO;
        end else begin
          ctrl.err = 1'b1;
        end
      end
    end
  end

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.err |-> (!ctrl.maskWe && !ctrl.rdEn)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !regValid |-> (!ctrl.err && !ctrl.maskWe && !ctrl.rdEn)); // R10

  AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite) |-> !ctrl.rdEn); // R9

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int NUM_CPU   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          ctrl,
  input  logic [REG_W-1:0]     regWdata,
  input  logic [NUM_LINES-1:0] devSet,
  input  logic [NUM_LINES-1:0] devClr,
  output logic [REG_W-1:0]     regRdata,
  output logic                 regErr,
  output logic [NUM_CPU-1:0]   cpuIrq
);

  logic [NUM_LINES-1:0] rawQ;
  logic [NUM_LINES-1:0] rawNext;
  logic [NUM_LINES-1:0] maskQ    [NUM_CPU];
  logic [NUM_LINES-1:0] maskNext [NUM_CPU];
  logic [NUM_LINES-1:0] vecQ     [NUM_CPU];
  logic [NUM_CPU-1:0]   irqQ;

  // set takes priority over clear on the same line
  assign rawNext = (rawQ & ~devClr) | devSet;

  always_ff @(posedge clk) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= rawNext;
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : gSlot
    assign maskNext[i] = (ctrl.maskWe && ctrl.slot == SLOT_IDX_W'(i)) ?
                         regWdata[NUM_LINES-1:0] : maskQ[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[i] <= '0;
        vecQ[i]  <= '0;
        irqQ[i]  <= 1'b0;
      end else begin
        maskQ[i] <= maskNext[i];
        vecQ[i]  <= maskNext[i] & rawNext;
        irqQ[i]  <= |vecQ[i];
      end
    end

    AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      vecQ[i] == (maskQ[i] & rawQ)); // R1

    AST_SET_REACHES: assert property (@(posedge clk) disable iff (!rstN)
      (|(devSet & maskNext[i])) |=> (vecQ[i] != '0)); // R4

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (cpuIrq[i] == $past(vecQ[i] != '0))); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !(ctrl.maskWe && ctrl.slot == SLOT_IDX_W'(i)) |=> $stable(maskQ[i])); // R9
  end

  assign cpuIrq = irqQ;

  logic [NUM_LINES-1:0] rdLine;
  logic [REG_W-1:0]     rdVal;

  always_comb begin
    case (ctrl.rdKind)
      RD_MASK: rdLine = maskQ[ctrl.slot];
      RD_VEC:  rdLine = vecQ[ctrl.slot];
      default: rdLine = rawQ;
    endcase
    rdVal = '0;
    rdVal[NUM_LINES-1:0] = rdLine;
    if (ctrl.rdKind == RD_RAW_LO) rdVal[REG_W-1:REG_W/2] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdata <= '0;
      regErr   <= 1'b0;
    end else begin
      regRdata <= ctrl.rdEn ? rdVal : '0;
      regErr   <= ctrl.err;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (|devSet) |=> ((rawQ & $past(devSet)) == $past(devSet))); // R6

  AST_RAW_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!(|devSet) && !(|devClr)) |=> $stable(rawQ)); // R5

  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regErr |-> (regRdata == '0)); // R9

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_LINES = 64,
  parameter int NUM_CPU   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [1:0]           regSize,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  output logic                 regErr,
  input  logic [NUM_LINES-1:0] devSet,
  input  logic [NUM_LINES-1:0] devClr,
  output logic [NUM_CPU-1:0]   cpuIrq
);

  ctrlStrobe_t ctrl;

  irq_route_ctrl #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regSize  (regSize),
    .ctrl     (ctrl)
  );

  irq_route_dp #(.NUM_LINES(NUM_LINES), .NUM_CPU(NUM_CPU)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .regWdata (regWdata),
    .devSet   (devSet),
    .devClr   (devClr),
    .regRdata (regRdata),
    .regErr   (regErr),
    .cpuIrq   (cpuIrq)
  );

endmodule

// File: tb/tb_irq_route_top.sv
module tb_irq_route_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [1:0]  regSize = 2'd3;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic        regErr;
  logic [63:0] devSet = '0;
  logic [63:0] devClr = '0;
  logic [3:0]  cpuIrq;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  logic [63:0] maskM [4];
  logic [63:0] rawM;

  always #2 clk = ~clk;

  irq_route_top dut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regSize(regSize), .regWdata(regWdata),
    .regRdata(regRdata), .regErr(regErr), .devSet(devSet),
    .devClr(devClr), .cpuIrq(cpuIrq)
  );

  function automatic logic [11:0] maskAddr(int c); return 12'(c * 64); endfunction
  function automatic logic [11:0] vecAddr(int c);  return 12'((4 + c) * 64); endfunction
  localparam logic [11:0] RAW_ADDR = 12'h200;

  function automatic logic [3:0] expIrq();
    logic [3:0] r;
    for (int c = 0; c < 4; c++) r[c] = |(maskM[c] & rawM);
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                     input logic [63:0] wd, output logic [63:0] rd, output logic er);
    @(negedge clk);
    regValid = 1'b1; regWrite = wr; regAddr = a; regSize = sz; regWdata = wd;
    @(negedge clk);
    rd = regRdata; er = regErr;
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] s, input logic [63:0] c);
    @(negedge clk);
    devSet = s; devClr = c;
    @(negedge clk);
    devSet = '0; devClr = '0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [63:0] rd;
    logic er;
    rawM = '0;
    for (int c = 0; c < 4; c++) maskM[c] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq reset", 64'(cpuIrq), 64'h0);
    chk("R10 rdata idle", regRdata, 64'h0);
    chk("R10 err idle", 64'(regErr), 64'h0);
    for (int c = 0; c < 4; c++) begin
      acc(1'b0, maskAddr(c), 2'd3, '0, rd, er);
      chk("R10 mask reset", rd, 64'h0);
      chk("R10 valid read no err", 64'(er), 64'h0);
    end
    acc(1'b0, RAW_ADDR, 2'd3, '0, rd, er);
    chk("R10 raw reset", rd, 64'h0);

    // R2 program distinct masks, R7 map
    maskM[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    maskM[1] = 64'h5555_5555_5555_5555;
    maskM[2] = 64'hFFFF_0000_0000_0000;
    maskM[3] = 64'h0000_0000_0000_0000;
    for (int c = 0; c < 4; c++) begin
      acc(1'b1, maskAddr(c), 2'd3, maskM[c], rd, er);
      chk("R2 mask write err", 64'(er), 64'h0);
    end
    for (int c = 0; c < 4; c++) begin
      acc(1'b0, maskAddr(c), 2'd3, '0, rd, er);
      chk("R2 R7 mask readback", rd, maskM[c]);
    end

    // R4 R3 R1 R5 sweep of every line
    for (int n = 0; n < 64; n++) begin
      pulse(64'h1 << n, '0);
      rawM = rawM | (64'h1 << n);
      @(negedge clk);
      chk("R4 R3 irq after set", 64'(cpuIrq), 64'(expIrq()));
      acc(1'b0, RAW_ADDR, 2'd3, '0, rd, er);
      chk("R4 raw after set", rd, rawM);
      for (int c = 0; c < 4; c++) begin
        acc(1'b0, vecAddr(c), 2'd3, '0, rd, er);
        chk("R1 vec", rd, maskM[c] & rawM);
      end
      pulse('0, 64'h1 << n);
      rawM = rawM & ~(64'h1 << n);
      @(negedge clk);
      chk("R5 irq after clear", 64'(cpuIrq), 64'(expIrq()));
      acc(1'b0, RAW_ADDR, 2'd3, '0, rd, er);
      chk("R5 raw after clear", rd, rawM);
    end

    // R5 clear of idle line ignored
    pulse(64'h1 << 5, '0);
    rawM = 64'h1 << 5;
    pulse('0, 64'h1 << 9);
    acc(1'b0, RAW_ADDR, 2'd3, '0, rd, er);
    chk("R5 idle clear ignored", rd, rawM);
    chk("R5 irq unchanged", 64'(cpuIrq), 64'(expIrq()));

    // R6 set wins over simultaneous clear
    pulse(64'h1 << 7, 64'h1 << 7);
    rawM = rawM | (64'h1 << 7);
    acc(1'b0, RAW_ADDR, 2'd3, '0, rd, er);
    chk("R6 set wins", rd, rawM);

    // R2 mask write raises then withdraws slot 3
    maskM[3] = 64'h1 << 7;
    acc(1'b1, maskAddr(3), 2'd3, maskM[3], rd, er);
    @(negedge clk);
    chk("R2 enable raises irq3", 64'(cpuIrq[3]), 64'h1);
    maskM[3] = 64'h1 << 20;
    acc(1'b1, maskAddr(3), 2'd3, maskM[3], rd, er);
    @(negedge clk);
    chk("R2 disable withdraws irq3", 64'(cpuIrq[3]), 64'h0);
    acc(1'b0, vecAddr(3), 2'd3, '0, rd, er);
    chk("R2 vec3 after mask write", rd, 64'h0);

    // R8 sizes
    pulse(64'h1 << 40, '0);
    rawM = rawM | (64'h1 << 40);
    acc(1'b0, RAW_ADDR, 2'd2, '0, rd, er);
    chk("R8 32-bit raw read", rd, {32'h0, rawM[31:0]});
    chk("R8 32-bit raw read no err", 64'(er), 64'h0);
    acc(1'b0, maskAddr(0), 2'd2, '0, rd, er);
    chk("R8 32-bit mask read data", rd, 64'h0);
    chk("R8 32-bit mask read err", 64'(er), 64'h1);
    acc(1'b0, RAW_ADDR, 2'd1, '0, rd, er);
    chk("R8 16-bit read err", 64'(er), 64'h1);

    // R9 unsupported writes leave state
    acc(1'b1, RAW_ADDR, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, er);
    chk("R9 raw write err", 64'(er), 64'h1);
    acc(1'b1, vecAddr(1), 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, rd, er);
    chk("R9 vec write err", 64'(er), 64'h1);
    acc(1'b1, maskAddr(1), 2'd2, 64'h0, rd, er);
    chk("R9 32-bit mask write err", 64'(er), 64'h1);
    acc(1'b1, 12'h048, 2'd3, 64'h0, rd, er);
    chk("R9 misaligned write err", 64'(er), 64'h1);
    acc(1'b1, 12'h240, 2'd3, 64'h0, rd, er);
    chk("R9 unmapped write err", 64'(er), 64'h1);
    acc(1'b0, 12'h240, 2'd3, 64'h0, rd, er);
    chk("R9 unmapped read data", rd, 64'h0);
    chk("R9 unmapped read err", 64'(er), 64'h1);
    acc(1'b0, RAW_ADDR, 2'd3, '0, rd, er);
    chk("R9 raw intact", rd, rawM);
    acc(1'b0, maskAddr(1), 2'd3, '0, rd, er);
    chk("R9 mask1 intact", rd, maskM[1]);
    acc(1'b0, vecAddr(1), 2'd3, '0, rd, er);
    chk("R9 R1 vec1 intact", rd, maskM[1] & rawM);

    // R10 error is a single pulse, idle data zero
    @(negedge clk);
    chk("R10 err one cycle", 64'(regErr), 64'h0);
    chk("R10 idle rdata", regRdata, 64'h0);
    chk("R3 final irq", 64'(cpuIrq), 64'(expIrq()));

    done = 1;
    finishRun();
  end

endmodule